// File: doc/BRIEF.md
# OSD Background Window Generator

This block draws a solid rectangular background panel for an on-screen display overlay, with an optional drop shadow cast to the lower right. It runs on the pixel clock and keeps its own position in the raster: a column counter that restarts on every horizontal sync and a scan-line counter that restarts on every vertical sync. Each clock it reports whether the current pixel is part of the panel, part of its shadow, or neither, together with three colour bits for the overlay mixer.

The panel's top edge is set by a coarse vertical delay, counted in steps of four scan lines from the start of the field. Below that origin, rows are numbered from zero and compared with the programmed first and last rows; columns are compared with the programmed first and last columns. The shadow is the same rectangle moved right by a programmable width and down by a programmable height, with the panel drawn on top, so it shows as a right strip, a bottom strip and the lower-right corner. All settings are captured once per field, so software may rewrite them at any time without tearing the picture.

Top module: `osd_bgwin`

## Requirements
- R1: While reset is asserted and until the first rising edge of `vsync` after reset, `win_active`, `shad_active` and `rgb` are all zero.
- R2: The column index is 0 on the clock after the one in which a rising edge of `hsync` is sampled and then rises by one each clock; pixels are compared against this index.
- R3: The scan-line index is 0 after a rising edge of `vsync` and rises by one on each later rising edge of `hsync`; panel row 0 is scan line `4 * cfg_vdelay`.
- R4: `win_active` is 1 exactly when the panel is enabled and column and row both lie within the inclusive bounds `cfg_col_lo..cfg_col_hi` and `cfg_row_lo..cfg_row_hi`; `rgb` then equals `cfg_win_rgb` (bit 2 red, bit 1 green, bit 0 blue).
- R5: The shadow covers columns `cfg_col_lo+cfg_shd_w .. cfg_col_hi+cfg_shd_w` and rows `cfg_row_lo+cfg_shd_h .. cfg_row_hi+cfg_shd_h`, including the lower-right corner; there `shad_active` is 1 and `rgb` equals `cfg_shd_rgb`.
- R6: Where panel and shadow overlap, the panel wins: `shad_active` is never 1 while `win_active` is 1.
- R7: Outside both panel and shadow, `win_active` and `shad_active` are 0 and `rgb` is 000.
- R8: With `cfg_shd_en` at 0 no shadow is produced; with `cfg_win_en` at 0 neither panel nor shadow is produced.
- R9: A programmed vertical delay of 0 is treated as 1 (panel origin at scan line 4).
- R10: Settings are captured only on a rising edge of `vsync`; a change in the middle of a field takes effect from the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync, leading edge is the rising edge |
| vsync | input | 1 | Vertical sync, leading edge is the rising edge |
| cfg_win_en | input | 1 | Panel enable |
| cfg_row_lo | input | LINE_W | First panel row |
| cfg_row_hi | input | LINE_W | Last panel row |
| cfg_col_lo | input | PIX_W | First panel column |
| cfg_col_hi | input | PIX_W | Last panel column |
| cfg_win_rgb | input | 3 | Panel colour {R,G,B} |
| cfg_shd_en | input | 1 | Shadow enable |
| cfg_shd_w | input | OFS_W | Shadow width in pixels |
| cfg_shd_h | input | OFS_W | Shadow height in scan lines |
| cfg_shd_rgb | input | 3 | Shadow colour {R,G,B} |
| cfg_vdelay | input | VD_W | Vertical delay in steps of four scan lines |
| win_active | output | 1 | Current pixel is inside the panel |
| shad_active | output | 1 | Current pixel is inside the visible shadow |
| rgb | output | 3 | Colour of the current pixel {R,G,B} |

## Verification
A column counter that slips by one shifts every panel and shadow edge by one pixel on the very next line, so the per-clock comparison against the bench's raster model shows it within one line period. A wrong line count or a wrong origin (for instance a zero delay not clamped) moves the top edge by whole scan lines and appears on the first line the panel should start or stop. A capture register that loads at the wrong time shows up as a panel edge that moves during the field in which settings were rewritten, in the same cycle as the first affected pixel.

// File: rtl/osd_bgw_pkg.sv
package osd_bgw_pkg;

   // Colour triple as delivered to the overlay mixer, red in the top bit
   typedef struct packed {
      logic r;
      logic g;
      logic b;
   } osd_rgb_t;

   // Which layer owns the current pixel
   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_SHADOW = 2'd1,
      REG_PANEL  = 2'd2
   } osd_region_e;

endpackage

// File: rtl/osd_raster_cnt.sv
module osd_raster_cnt #(
   parameter int PIX_W  = 11,
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   output logic              field_start,
   output logic [PIX_W-1:0]  pix,
   output logic [LINE_W-1:0] ln
);

   localparam logic [PIX_W-1:0]  PIX_TOP  = '1;
   localparam logic [LINE_W-1:0] LINE_TOP = '1;

   logic hs_q, vs_q;
   logic hs_edge;

   assign hs_edge     = hsync & ~hs_q;
   assign field_start = vsync & ~vs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         vs_q <= 1'b0;
         pix  <= '0;
         ln   <= '0;
      end else begin
         hs_q <= hsync;
         vs_q <= vsync;
         // column index, saturating on a missing sync
         if (hs_edge)
            pix <= '0;
         else if (pix != PIX_TOP)
            pix <= pix + 1'b1;
         // scan-line index; a field start wins over a line start
         if (field_start)
            ln <= '0;
         else if (hs_edge && ln != LINE_TOP)
            ln <= ln + 1'b1;
      end
   end

endmodule

// File: rtl/osd_field_hold.sv
module osd_field_hold #(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] d,
   output logic [CFG_W-1:0] q
);

   if (CFG_W < 1) begin : g_bad_width
      $error("osd_field_hold: CFG_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= d;
   end

endmodule

// File: rtl/osd_rect_hit.sv
module osd_rect_hit #(
   parameter int X_W = 11,
   parameter int Y_W = 10,
   parameter int O_W = 4
) (
   input  logic [X_W-1:0] x,
   input  logic [Y_W-1:0] y,
   input  logic           y_ok,
   input  logic [X_W-1:0] x_lo,
   input  logic [X_W-1:0] x_hi,
   input  logic [Y_W-1:0] y_lo,
   input  logic [Y_W-1:0] y_hi,
   input  logic [O_W-1:0] x_ofs,
   input  logic [O_W-1:0] y_ofs,
   output logic           hit
);

   // one guard bit so that bound + offset never wraps
   localparam int XE = X_W + 1;
   localparam int YE = Y_W + 1;

   if (O_W > X_W || O_W > Y_W) begin : g_bad_ofs
      $error("osd_rect_hit: offset wider than a coordinate");
   end

   logic [XE-1:0] xv, xl, xh;
   logic [YE-1:0] yv, yl, yh;

   assign xv = {1'b0, x};
   assign yv = {1'b0, y};
   assign xl = {1'b0, x_lo} + XE'(x_ofs);
   assign xh = {1'b0, x_hi} + XE'(x_ofs);
   assign yl = {1'b0, y_lo} + YE'(y_ofs);
   assign yh = {1'b0, y_hi} + YE'(y_ofs);

   assign hit = y_ok && (xv >= xl) && (xv <= xh) && (yv >= yl) && (yv <= yh);

endmodule

// File: rtl/osd_bgwin.sv
module osd_bgwin
   import osd_bgw_pkg::*;
#(
   parameter int PIX_W          = 11,
   parameter int LINE_W         = 10,
   parameter int OFS_W          = 4,
   parameter int VD_W           = 8,
   parameter int LINES_PER_STEP = 4,
   parameter bit SHADOW_EN      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              cfg_win_en,
   input  logic [LINE_W-1:0] cfg_row_lo,
   input  logic [LINE_W-1:0] cfg_row_hi,
   input  logic [PIX_W-1:0]  cfg_col_lo,
   input  logic [PIX_W-1:0]  cfg_col_hi,
   input  logic [2:0]        cfg_win_rgb,
   input  logic              cfg_shd_en,
   input  logic [OFS_W-1:0]  cfg_shd_w,
   input  logic [OFS_W-1:0]  cfg_shd_h,
   input  logic [2:0]        cfg_shd_rgb,
   input  logic [VD_W-1:0]   cfg_vdelay,
   output logic              win_active,
   output logic              shad_active,
   output logic [2:0]        rgb
);

   localparam int STEP_SH   = $clog2(LINES_PER_STEP);
   localparam bit STEP_POW2 = ((1 << STEP_SH) == LINES_PER_STEP);
   localparam int ORG_W     = VD_W + $clog2(LINES_PER_STEP + 1);
   localparam int CFG_W     = 2 + 2*LINE_W + 2*PIX_W + 6 + 2*OFS_W + VD_W;

   if (LINES_PER_STEP < 1) begin : g_bad_step
      $error("osd_bgwin: LINES_PER_STEP must be at least 1");
   end
   if (VD_W < 1 || PIX_W < 2 || LINE_W < 2) begin : g_bad_dims
      $error("osd_bgwin: counter or delay width too small");
   end

   // ---------------- raster position ----------------
   logic              field_start;
   logic [PIX_W-1:0]  pix_cnt;
   logic [LINE_W-1:0] ln_cnt;

   osd_raster_cnt #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_raster (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .field_start(field_start), .pix(pix_cnt), .ln(ln_cnt)
   );

   // ---------------- per-field capture ----------------
   logic [CFG_W-1:0]  cfg_live, cfg_held;
   logic              h_win_en, h_shd_en;
   logic [LINE_W-1:0] h_row_lo, h_row_hi;
   logic [PIX_W-1:0]  h_col_lo, h_col_hi;
   logic [2:0]        h_win_rgb, h_shd_rgb;
   logic [OFS_W-1:0]  h_shd_w, h_shd_h;
   logic [VD_W-1:0]   h_vdelay;

   assign cfg_live = {cfg_win_en, cfg_row_lo, cfg_row_hi, cfg_col_lo, cfg_col_hi,
                      cfg_win_rgb, cfg_shd_en, cfg_shd_w, cfg_shd_h, cfg_shd_rgb,
                      cfg_vdelay};

   osd_field_hold #(.CFG_W(CFG_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(field_start), .d(cfg_live), .q(cfg_held)
   );

   assign {h_win_en, h_row_lo, h_row_hi, h_col_lo, h_col_hi,
           h_win_rgb, h_shd_en, h_shd_w, h_shd_h, h_shd_rgb,
           h_vdelay} = cfg_held;

   // ---------------- vertical origin ----------------
   logic [VD_W-1:0]   vd_eff;
   logic [ORG_W-1:0]  origin;
   logic              row_ok;
   logic [LINE_W-1:0] row;

   assign vd_eff = (h_vdelay == '0) ? VD_W'(1) : h_vdelay;

   if (STEP_POW2) begin : g_org_shift
      assign origin = ORG_W'(vd_eff) << STEP_SH;
   end else begin : g_org_mul
      assign origin = ORG_W'(vd_eff) * ORG_W'(LINES_PER_STEP);
   end

   assign row_ok = ORG_W'(ln_cnt) >= origin;
   assign row    = ln_cnt - LINE_W'(origin);

   // ---------------- area tests ----------------
   logic panel_hit, shd_area;

   osd_rect_hit #(.X_W(PIX_W), .Y_W(LINE_W), .O_W(OFS_W)) u_panel_hit (
      .x(pix_cnt), .y(row), .y_ok(row_ok),
      .x_lo(h_col_lo), .x_hi(h_col_hi), .y_lo(h_row_lo), .y_hi(h_row_hi),
      .x_ofs('0), .y_ofs('0), .hit(panel_hit)
   );

   if (SHADOW_EN) begin : g_shadow
      logic shd_hit;
      osd_rect_hit #(.X_W(PIX_W), .Y_W(LINE_W), .O_W(OFS_W)) u_shd_hit (
         .x(pix_cnt), .y(row), .y_ok(row_ok),
         .x_lo(h_col_lo), .x_hi(h_col_hi), .y_lo(h_row_lo), .y_hi(h_row_hi),
         .x_ofs(h_shd_w), .y_ofs(h_shd_h), .hit(shd_hit)
      );
      assign shd_area = shd_hit & h_shd_en;
   end else begin : g_no_shadow
      assign shd_area = 1'b0;
   end

   // ---------------- layer select ----------------
   osd_region_e region;
   osd_rgb_t    pix_colour;

   always_comb begin
      region = REG_NONE;
      if (h_win_en) begin
         if (panel_hit)
            region = REG_PANEL;
         else if (shd_area)
            region = REG_SHADOW;
      end
   end

   always_comb begin
      case (region)
         REG_PANEL:  pix_colour = osd_rgb_t'(h_win_rgb);
         REG_SHADOW: pix_colour = osd_rgb_t'(h_shd_rgb);
         default:    pix_colour = '0;
      endcase
   end

   assign win_active  = (region == REG_PANEL);
   assign shad_active = (region == REG_SHADOW);
   assign rgb         = pix_colour;

endmodule

// File: rtl/osd_bgwin_chk.sv
module osd_bgwin_chk #(
   parameter int PIX_W = 11,
   parameter int VD_W  = 8,
   parameter int CFG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hsync,
   input logic             vsync,
   input logic             win_active,
   input logic             shad_active,
   input logic [2:0]       rgb,
   input logic [PIX_W-1:0] pix,
   input logic [VD_W-1:0]  vd_eff,
   input logic [CFG_W-1:0] cfg_held,
   input logic [2:0]       win_rgb_h,
   input logic             shd_en_h,
   input logic             win_en_h
);

   // sync history of the checker's own, cleared by reset
   logic hs_prev, vs_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_prev <= 1'b0;
         vs_prev <= 1'b0;
      end else begin
         hs_prev <= hsync;
         vs_prev <= vsync;
      end
   end

   p_col_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync && !hs_prev) |=> (pix == '0));

   p_panel_colour_r4: assert property (@(posedge clk) disable iff (!rst_n)
      win_active |-> (rgb == win_rgb_h));

   p_panel_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      win_active |-> !shad_active);

   p_idle_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_active || shad_active) |-> (rgb == 3'b000));

   p_shadow_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !shd_en_h |-> !shad_active);

   p_panel_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en_h |-> !(win_active || shad_active));

   p_delay_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vd_eff != '0);

   p_field_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(vsync && !vs_prev) |=> $stable(cfg_held));

endmodule

bind osd_bgwin osd_bgwin_chk #(.PIX_W(PIX_W), .VD_W(VD_W), .CFG_W(CFG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
   .win_active(win_active), .shad_active(shad_active), .rgb(rgb),
   .pix(pix_cnt), .vd_eff(vd_eff), .cfg_held(cfg_held),
   .win_rgb_h(h_win_rgb), .shd_en_h(h_shd_en), .win_en_h(h_win_en)
);

// File: tb/osd_bgwin_test.sv
`timescale 1ns/1ps
module osd_bgwin_test;

   localparam int PIX_W  = 11;
   localparam int LINE_W = 10;
   localparam int OFS_W  = 4;
   localparam int VD_W   = 8;
   localparam int LINE_LEN = 40;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0;
   logic              hsync = 1'b0, vsync = 1'b0;
   logic              cfg_win_en = 1'b0, cfg_shd_en = 1'b0;
   logic [LINE_W-1:0] cfg_row_lo = '0, cfg_row_hi = '0;
   logic [PIX_W-1:0]  cfg_col_lo = '0, cfg_col_hi = '0;
   logic [2:0]        cfg_win_rgb = '0, cfg_shd_rgb = '0;
   logic [OFS_W-1:0]  cfg_shd_w = '0, cfg_shd_h = '0;
   logic [VD_W-1:0]   cfg_vdelay = '0;
   logic              win_active, shad_active;
   logic [2:0]        rgb;

   osd_bgwin uut (
      .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
      .cfg_win_en(cfg_win_en), .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi),
      .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi), .cfg_win_rgb(cfg_win_rgb),
      .cfg_shd_en(cfg_shd_en), .cfg_shd_w(cfg_shd_w), .cfg_shd_h(cfg_shd_h),
      .cfg_shd_rgb(cfg_shd_rgb), .cfg_vdelay(cfg_vdelay),
      .win_active(win_active), .shad_active(shad_active), .rgb(rgb)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   int    shd_seen = 0;
   bit    done = 0;
   string cur_req = "R1";

   // ---------------- behavioural raster model ----------------
   int m_pix, m_line;
   bit m_hp, m_vp, m_hr, m_vr;
   int k_en, k_rlo, k_rhi, k_clo, k_chi, k_wrgb, k_sen, k_m, k_n, k_srgb, k_vd;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pix = 0; m_line = 0; m_hp = 0; m_vp = 0;
         k_en = 0; k_rlo = 0; k_rhi = 0; k_clo = 0; k_chi = 0; k_wrgb = 0;
         k_sen = 0; k_m = 0; k_n = 0; k_srgb = 0; k_vd = 0;
      end else begin
         m_hr = hsync && !m_hp;
         m_vr = vsync && !m_vp;
         if (m_hr) m_pix = 0;
         else if (m_pix < (1 << PIX_W) - 1) m_pix++;
         if (m_vr) begin
            m_line = 0;
            k_en = cfg_win_en; k_rlo = cfg_row_lo; k_rhi = cfg_row_hi;
            k_clo = cfg_col_lo; k_chi = cfg_col_hi; k_wrgb = cfg_win_rgb;
            k_sen = cfg_shd_en; k_m = cfg_shd_w; k_n = cfg_shd_h;
            k_srgb = cfg_shd_rgb; k_vd = cfg_vdelay;
         end else if (m_hr && m_line < (1 << LINE_W) - 1) begin
            m_line++;
         end
         m_hp = hsync;
         m_vp = vsync;
      end
   end

   task automatic model_out(output bit w, output bit s, output int c);
      int org, row;
      bit in_w, in_s;
      org = 4 * ((k_vd == 0) ? 1 : k_vd);   // R9 clamp, R3 origin
      row = m_line - org;
      w = 0; s = 0; c = 0;
      if (k_en != 0 && m_line >= org) begin
         in_w = (m_pix >= k_clo) && (m_pix <= k_chi) && (row >= k_rlo) && (row <= k_rhi);
         in_s = (k_sen != 0) && (m_pix >= k_clo + k_m) && (m_pix <= k_chi + k_m)
                && (row >= k_rlo + k_n) && (row <= k_rhi + k_n);
         if (in_w) begin w = 1; c = k_wrgb; end
         else if (in_s) begin s = 1; c = k_srgb; end
      end
   endtask

   task automatic check_bit(string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d (line %0d pix %0d)",
                  cur_req, what, act, exp, m_line, m_pix);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      bit ew, es;
      int ec;
      if (!done) begin
         model_out(ew, es, ec);
         check_bit("win_active", int'(win_active), int'(ew));
         check_bit("shad_active", int'(shad_active), int'(es));
         check_bit("rgb", int'(rgb), ec);
         if (es && shad_active) shd_seen++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic drive_line(bit vs);
      for (int i = 0; i < LINE_LEN; i++) begin
         @(posedge clk); #1;
         hsync = (i < 2);
         vsync = vs;
      end
   endtask

   task automatic field(int nlines);
      drive_line(1'b1);
      for (int l = 1; l < nlines; l++) drive_line(1'b0);
   endtask

   task automatic cfg(int en, int rlo, int rhi, int clo, int chi, int wrgb,
                      int sen, int m, int n, int srgb, int vd);
      @(posedge clk); #1;
      cfg_win_en = en[0]; cfg_row_lo = LINE_W'(rlo); cfg_row_hi = LINE_W'(rhi);
      cfg_col_lo = PIX_W'(clo); cfg_col_hi = PIX_W'(chi); cfg_win_rgb = wrgb[2:0];
      cfg_shd_en = sen[0]; cfg_shd_w = OFS_W'(m); cfg_shd_h = OFS_W'(n);
      cfg_shd_rgb = srgb[2:0]; cfg_vdelay = VD_W'(vd);
   endtask

   initial begin
      // R1: reset state, with settings already programmed
      cur_req = "R1";
      cfg_win_en = 1; cfg_col_hi = 30; cfg_row_hi = 20; cfg_win_rgb = 3'b111; cfg_vdelay = 1;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int l = 0; l < 6; l++) drive_line(1'b0);   // R1: no field start yet

      cur_req = "R4";
      cfg(1, 2, 5, 5, 12, 3'b101, 1, 3, 2, 3'b010, 1);
      field(24);

      cur_req = "R5";
      shd_seen = 0;
      cfg(1, 1, 4, 8, 15, 3'b110, 1, 4, 3, 3'b001, 1);
      field(24);
      n_checks++;
      if (shd_seen == 0) begin
         n_errors++;
         $display("FAIL R5 shadow pixels: actual=%0d expected>0", shd_seen);
      end

      cur_req = "R2";   // panel from column 0
      cfg(1, 0, 3, 0, 3, 3'b011, 1, 2, 1, 3'b100, 1);
      field(20);

      cur_req = "R9";   // zero delay acts as one
      cfg(1, 0, 2, 4, 9, 3'b001, 1, 1, 1, 3'b110, 0);
      field(20);

      cur_req = "R3";   // origin at scan line 12
      cfg(1, 1, 3, 6, 10, 3'b010, 1, 2, 2, 3'b101, 3);
      field(24);

      cur_req = "R8";   // shadow disabled, then panel disabled
      cfg(1, 2, 5, 5, 12, 3'b101, 0, 3, 2, 3'b010, 1);
      field(20);
      cfg(0, 2, 5, 5, 12, 3'b101, 1, 3, 2, 3'b010, 1);
      field(20);

      cur_req = "R6";   // shadow mostly under the panel
      cfg(1, 0, 8, 2, 30, 3'b100, 1, 1, 1, 3'b011, 1);
      field(20);

      cur_req = "R7";   // panel near the line end, blank elsewhere
      cfg(1, 3, 4, 30, 34, 3'b111, 1, 3, 1, 3'b001, 2);
      field(20);

      cur_req = "R10";  // rewrite mid-field, effect only from the next field
      cfg(1, 1, 3, 5, 10, 3'b101, 1, 2, 1, 3'b010, 1);
      drive_line(1'b1);
      for (int l = 1; l < 6; l++) drive_line(1'b0);
      cfg(1, 0, 6, 15, 25, 3'b011, 1, 5, 3, 3'b100, 1);
      for (int l = 0; l < 14; l++) drive_line(1'b0);
      field(20);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1;
         n_errors++;
         $display("FAIL watchdog: run did not complete");
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule